// File: doc/BRIEF.md
# Multiplexed Bus Target Cycle Controller

This block is the slave end of a 32-bit parallel bus on which address and data share one set of lines, and command and byte enables share another. It watches the active-low frame line for the clock in which a new transaction starts. In that clock it captures the address and the four-bit command and compares them with three decode windows: an I/O window, a memory window and a configuration space that is selected by a separate chip-select line. When the transaction falls in one of them, the block claims it with device-select. It then steps through the data phases and holds target-ready high until a local backend reports that it is ready.

Read data comes from the backend and is driven onto the bus. Write data, together with the byte enables, is passed to the backend as a one-clock commit. A memory burst advances its address by one word after each beat. An I/O or configuration access always ends after one beat, because the block raises stop together with target-ready on that beat. The block drives even parity one clock after every read word it puts on the bus. All bus control lines are active-low. The reset is synchronous and active-low.

Top module: `tgt_bus_target`

## Requirements
- R1: While rstN is low at a clock edge, and after that edge, devselN, trdyN and stopN read 1, and adOe, parOe, beReq and beWrEn read 0.
- R2: An address phase is a clock edge at which frameN is 0 after being 1 at the previous edge. At that edge the block latches the address and the command, which cbeN carries with bit 3 as the MSB. The commands claimed are I/O read 0010, I/O write 0011, memory read 0110, memory write 0111, configuration read 1010 and configuration write 1011. For a claimed command, devselN goes to 0 right after that edge. The block claims no other code, including the reserved codes 0100, 0101, 1000 and 1001.
- R3: While the block waits for the backend, beReq is 1 and trdyN stays 1. trdyN goes to 0 right after the first edge at which beReady is sampled 1.
- R4: A beat completes only at an edge where trdyN and irdyN are both 0. While irdyN is 1, trdyN stays 0 and no beat completes. After a beat that is not the last one, trdyN returns to 1 and the block waits for the backend again.
- R5: For a read, adOut holds the beRdata value sampled at the edge that lowered trdyN, and adOe is 1 for as long as trdyN is 0.
- R6: One clock after a write beat completes, beWrEn is 1 for one clock. At the same time beWrData carries the adIn value sampled at completion, beWrMask carries the inverted cbeN (so bit n set means byte n is enabled), and beWrAddr carries the address of that beat.
- R7: Decode and backend address depend on the command type.
  - An I/O hit needs adIn[31:4] equal to the I/O base, and beAddr is the full byte address, bits 1:0 included.
  - A memory hit needs adIn[31:12] equal to the memory base, and beAddr has bits 1:0 forced to 0.
  - A configuration hit needs cfgSel at 1 and adIn[1:0] at 00, and beAddr is adIn[7:2] shifted left by two.
  - beSpace reads 0 for I/O, 1 for memory and 2 for configuration.
- R8: During a memory burst, beAddr increases by 4 after each completed beat, for any number of beats.
- R9: For I/O and configuration commands, stopN goes to 0 together with trdyN. The beat that completes with stopN at 0 ends the transaction. For memory commands, stopN stays 1.
- R10: When a beat completes with frameN at 1, devselN, trdyN and stopN all return to 1 right after that edge.
- R11: parOe equals adOe delayed by one clock. Whenever parOe is 1, parOut makes the number of ones across the previous clock's adOut and cbeN, together with parOut, even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active-low |
| frameN | input | 1 | Transaction frame from the initiator, active-low |
| irdyN | input | 1 | Initiator ready, active-low |
| cfgSel | input | 1 | Configuration chip-select, active-high |
| adIn | input | 32 | Address/data lines as seen on the bus |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in data phases |
| adOut | output | 32 | Read data to drive on the bus |
| adOe | output | 1 | Enable for adOut |
| parOut | output | 1 | Even parity of the previous clock's adOut and cbeN |
| parOe | output | 1 | Enable for parOut |
| devselN | output | 1 | Device select, active-low |
| trdyN | output | 1 | Target ready, active-low |
| stopN | output | 1 | Stop request, active-low |
| beReq | output | 1 | Backend access pending |
| beSpace | output | 2 | Space of the pending access: 0 I/O, 1 memory, 2 configuration |
| beWrite | output | 1 | Pending access is a write |
| beAddr | output | 32 | Address of the pending access |
| beReady | input | 1 | Backend can complete the pending access |
| beRdata | input | 32 | Backend read data, sampled while beReady is 1 |
| beWrEn | output | 1 | One-clock write commit |
| beWrData | output | 32 | Write data of the commit |
| beWrMask | output | 4 | Byte mask of the commit, active-high |
| beWrAddr | output | 32 | Address of the commit |

## Verification
The assertions assume that the initiator behaves. It raises frameN only in the data phase that it means to be the last. Once it has lowered irdyN, it keeps it low until the beat completes. It ends the transaction right after a beat that completed with stopN low. The stimulus tasks keep to all three rules. They can insert initiator wait states before irdyN goes low, and they give up on an unclaimed transaction after a few clocks instead of waiting for a claim. The backend model answers after a delay set for each transaction. It watches only beReq, so every mix of target-side and initiator-side wait states stays inside these rules.

// File: rtl/tgt_pkg.sv
`timescale 1ns/1ps
package tgt_pkg;

  // Address space of the current transaction
  typedef enum logic [1:0] {
    SPC_IO   = 2'd0,
    SPC_MEM  = 2'd1,
    SPC_CFG  = 2'd2,
    SPC_NONE = 2'd3
  } space_e;

  // Upper three command bits; bit 0 of the command selects write
  localparam logic [2:0] CMD_IO  = 3'b001;
  localparam logic [2:0] CMD_MEM = 3'b011;
  localparam logic [2:0] CMD_CFG = 3'b101;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic loadRead;
    logic beatDone;
  } strobe_t;

endpackage

// File: rtl/tgt_ctrl.sv
`timescale 1ns/1ps
module tgt_ctrl
  import tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameN,
  input  logic    irdyN,
  input  logic    hit,
  input  logic    isWrite,
  input  logic    isBurst,
  input  logic    beReady,
  output strobe_t stb,
  output logic    devselN,
  output logic    trdyN,
  output logic    stopN,
  output logic    adOe,
  output logic    beReq
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} state_e;

  state_e state;
  logic   prevFrameN;
  logic   addrPhase;
  logic   lastBeat;

  assign addrPhase = !frameN && prevFrameN;
  assign lastBeat  = frameN || !stopN;
  assign beReq     = (state == ST_WAIT);

  always_comb begin
    stb = '0;
    stb.latchAddr = (state == ST_IDLE) && addrPhase && hit;
    stb.loadRead  = (state == ST_WAIT) && beReady && !isWrite;
    stb.beatDone  = (state == ST_XFER) && !irdyN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
      devselN    <= 1'b1;
      trdyN      <= 1'b1;
      stopN      <= 1'b1;
      adOe       <= 1'b0;
    end else begin
      prevFrameN <= frameN;
      case (state)
        ST_IDLE: begin
          if (addrPhase && hit) begin
            devselN <= 1'b0;
            state   <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (beReady) begin
            trdyN <= 1'b0;
            stopN <= isBurst;
            adOe  <= !isWrite;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (!irdyN) begin
            trdyN <= 1'b1;
            adOe  <= 1'b0;
            if (lastBeat) begin
              devselN <= 1'b1;
              stopN   <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN); // R2

  AST_WAIT_NO_TRDY: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beReady) |=> trdyN); // R3

  AST_TRDY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && irdyN) |=> !trdyN); // R4

  AST_STOP_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> !trdyN); // R9

  AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN && frameN) |=> (devselN && trdyN && stopN)); // R10

endmodule

// File: rtl/tgt_datapath.sv
`timescale 1ns/1ps
module tgt_datapath
  import tgt_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter int          IO_AW    = 4,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          MEM_AW   = 12,
  parameter int          CFG_AW   = 8,
  localparam int         BEW      = DW / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   adIn,
  input  logic [BEW-1:0]  cbeN,
  input  logic            cfgSel,
  input  strobe_t         stb,
  input  logic            adOe,
  input  logic [DW-1:0]   beRdata,
  output logic            hit,
  output space_e          curSpace,
  output logic            isWrite,
  output logic [DW-1:0]   adOut,
  output logic [DW-1:0]   beAddr,
  output logic            beWrEn,
  output logic [DW-1:0]   beWrData,
  output logic [BEW-1:0]  beWrMask,
  output logic [DW-1:0]   beWrAddr,
  output logic            parOut,
  output logic            parOe
);

  localparam int LSB = $clog2(BEW);

  space_e        decSpace;
  logic [2:0]    cmdHi;
  logic          ioHit;
  logic          memHit;
  logic          cfgHit;
  logic [DW-1:0] cfgOffset;
  logic [DW-1:0] curAddr;
  logic [DW-1:0] rdReg;

  assign cmdHi  = cbeN[3:1];
  assign ioHit  = (cmdHi == CMD_IO)  && (adIn[DW-1:IO_AW]  == IO_BASE[DW-1:IO_AW]);
  assign memHit = (cmdHi == CMD_MEM) && (adIn[DW-1:MEM_AW] == MEM_BASE[DW-1:MEM_AW]);
  assign cfgHit = (cmdHi == CMD_CFG) && cfgSel && (adIn[LSB-1:0] == '0);
  assign cfgOffset = {{(DW-CFG_AW){1'b0}}, adIn[CFG_AW-1:LSB], {LSB{1'b0}}};

  always_comb begin
    if (ioHit)       decSpace = SPC_IO;
    else if (memHit) decSpace = SPC_MEM;
    else if (cfgHit) decSpace = SPC_CFG;
    else             decSpace = SPC_NONE;
  end

  assign hit    = (decSpace != SPC_NONE);
  assign beAddr = curAddr;
  assign adOut  = rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSpace <= SPC_NONE;
      isWrite  <= 1'b0;
      curAddr  <= '0;
      rdReg    <= '0;
      beWrEn   <= 1'b0;
      beWrData <= '0;
      beWrMask <= '0;
      beWrAddr <= '0;
      parOut   <= 1'b0;
      parOe    <= 1'b0;
    end else begin
      if (stb.latchAddr) begin
        curSpace <= decSpace;
        isWrite  <= cbeN[0];
        case (decSpace)
          SPC_IO:  curAddr <= adIn;
          SPC_MEM: curAddr <= {adIn[DW-1:LSB], {LSB{1'b0}}};
          default: curAddr <= cfgOffset;
        endcase
      end else if (stb.beatDone && curSpace == SPC_MEM) begin
        curAddr <= curAddr + DW'(BEW);
      end
      if (stb.loadRead) rdReg <= beRdata;
      beWrEn <= stb.beatDone && isWrite;
      if (stb.beatDone && isWrite) begin
        beWrData <= adIn;
        beWrMask <= ~cbeN;
        beWrAddr <= curAddr;
      end
      parOut <= ^{rdReg, cbeN};
      parOe  <= adOe;
    end
  end

  AST_SPACE_KNOWN_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRead |-> (curSpace != SPC_NONE)); // R7

endmodule

// File: rtl/tgt_bus_target.sv
`timescale 1ns/1ps
module tgt_bus_target
  import tgt_pkg::*;
#(
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  parameter int          IO_AW    = 4,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          MEM_AW   = 12,
  parameter int          CFG_AW   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        cfgSel,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        parOut,
  output logic        parOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN,
  output logic        beReq,
  output logic [1:0]  beSpace,
  output logic        beWrite,
  output logic [31:0] beAddr,
  input  logic        beReady,
  input  logic [31:0] beRdata,
  output logic        beWrEn,
  output logic [31:0] beWrData,
  output logic [3:0]  beWrMask,
  output logic [31:0] beWrAddr
);

  strobe_t stb;
  logic    hit;
  space_e  curSpace;
  logic    isWrite;

  assign beSpace = curSpace;
  assign beWrite = isWrite;

  tgt_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .hit     (hit),
    .isWrite (isWrite),
    .isBurst (curSpace == SPC_MEM),
    .beReady (beReady),
    .stb     (stb),
    .devselN (devselN),
    .trdyN   (trdyN),
    .stopN   (stopN),
    .adOe    (adOe),
    .beReq   (beReq)
  );

  tgt_datapath #(
    .DW       (32),
    .IO_BASE  (IO_BASE),
    .IO_AW    (IO_AW),
    .MEM_BASE (MEM_BASE),
    .MEM_AW   (MEM_AW),
    .CFG_AW   (CFG_AW)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .adIn     (adIn),
    .cbeN     (cbeN),
    .cfgSel   (cfgSel),
    .stb      (stb),
    .adOe     (adOe),
    .beRdata  (beRdata),
    .hit      (hit),
    .curSpace (curSpace),
    .isWrite  (isWrite),
    .adOut    (adOut),
    .beAddr   (beAddr),
    .beWrEn   (beWrEn),
    .beWrData (beWrData),
    .beWrMask (beWrMask),
    .beWrAddr (beWrAddr),
    .parOut   (parOut),
    .parOe    (parOe)
  );

  AST_COMMIT_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    beWrEn |-> $past(!trdyN && !irdyN)); // R6

  AST_PARITY_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> $past(adOe)); // R11

endmodule

// File: tb/test_tgt_bus_target.sv
`timescale 1ns/1ps
module test_tgt_bus_target;

  localparam logic [31:0] IOB  = 32'h0000_1000;
  localparam logic [31:0] MEMB = 32'h8000_0000;
  localparam logic [31:0] RDX  = 32'hA5A5_0F0F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1, cfgSel = 1'b0;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adOut, beAddr, beRdata, beWrData, beWrAddr;
  logic        adOe, parOut, parOe, devselN, trdyN, stopN, beReq, beWrite, beWrEn;
  logic [1:0]  beSpace;
  logic [3:0]  beWrMask;
  logic        beReady = 1'b0;

  int checks = 0, errors = 0, cyc = 0, rdyCnt = 0, rdyDelay = 0;
  bit started = 0;

  always #5 clk = ~clk;

  assign beRdata = beAddr ^ RDX;

  tgt_bus_target i_tgt_bus_target (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cfgSel(cfgSel),
    .adIn(adIn), .cbeN(cbeN), .adOut(adOut), .adOe(adOe), .parOut(parOut),
    .parOe(parOe), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
    .beReq(beReq), .beSpace(beSpace), .beWrite(beWrite), .beAddr(beAddr),
    .beReady(beReady), .beRdata(beRdata), .beWrEn(beWrEn), .beWrData(beWrData),
    .beWrMask(beWrMask), .beWrAddr(beWrAddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Backend: ready after rdyDelay clocks of a pending request
  always @(negedge clk) begin
    if (beReq) begin
      beReady = (rdyCnt >= rdyDelay);
      rdyCnt  = rdyCnt + 1;
    end else begin
      beReady = 1'b0;
      rdyCnt  = 0;
    end
  end

  // Behavioural reference model, stepped on each rising edge
  int          mState = 0;     // 0 idle, 1 waiting for backend, 2 transferring
  int          mSpace = 3;     // 0 io, 1 mem, 2 cfg, 3 none
  bit          mPrevFrame = 1, mDevsel = 1, mTrdy = 1, mStop = 1, mOe = 0;
  bit          mWrite = 0, mParOe = 0, mPar = 0, mWrEn = 0;
  logic [31:0] mAddr = '0, mRd = '0, mWrData = '0, mWrAddr = '0;
  logic [3:0]  mWrMask = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mState = 0; mSpace = 3; mPrevFrame = 1; mDevsel = 1; mTrdy = 1; mStop = 1;
      mOe = 0; mParOe = 0; mWrEn = 0; mRd = '0; mAddr = '0;
    end else begin
      mWrEn  = 0;
      mParOe = mOe;
      mPar   = ^{mRd, cbeN};
      case (mState)
        0: if (!frameN && mPrevFrame) begin
          mSpace = 3;
          if (cbeN[3:1] == 3'b001 && adIn[31:4] == IOB[31:4]) mSpace = 0;
          else if (cbeN[3:1] == 3'b011 && adIn[31:12] == MEMB[31:12]) mSpace = 1;
          else if (cbeN[3:1] == 3'b101 && cfgSel && adIn[1:0] == 2'b00) mSpace = 2;
          if (mSpace != 3) begin
            mWrite  = cbeN[0];
            mDevsel = 0;
            mState  = 1;
            if (mSpace == 0) mAddr = adIn;
            else if (mSpace == 1) mAddr = {adIn[31:2], 2'b00};
            else mAddr = {24'h0, adIn[7:2], 2'b00};
          end
        end
        1: if (beReady) begin
          mTrdy = 0;
          mStop = (mSpace == 1);
          mOe   = !mWrite;
          if (!mWrite) mRd = mAddr ^ RDX;
          mState = 2;
        end
        default: if (!irdyN) begin
          if (mWrite) begin
            mWrEn = 1; mWrData = adIn; mWrMask = ~cbeN; mWrAddr = mAddr;
          end
          mTrdy = 1; mOe = 0;
          if (frameN || !mStop) begin
            mDevsel = 1; mStop = 1; mState = 0;
          end else begin
            mState = 1;
          end
          if (mSpace == 1) mAddr = mAddr + 32'd4;
        end
      endcase
      mPrevFrame = frameN;
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      chk("R2 R10 devselN", {31'b0, devselN}, {31'b0, mDevsel});
      chk("R3 R4 trdyN", {31'b0, trdyN}, {31'b0, mTrdy});
      chk("R9 stopN", {31'b0, stopN}, {31'b0, mStop});
      chk("R5 adOe", {31'b0, adOe}, {31'b0, mOe});
      if (mOe) chk("R5 adOut", adOut, mRd);
      chk("R3 beReq", {31'b0, beReq}, {31'b0, (mState == 1)});
      if (mState == 1) begin
        chk("R7 R8 beAddr", beAddr, mAddr);
        chk("R7 beSpace", {30'b0, beSpace}, mSpace);
        chk("R6 beWrite", {31'b0, beWrite}, {31'b0, mWrite});
      end
      chk("R11 parOe", {31'b0, parOe}, {31'b0, mParOe});
      if (mParOe) chk("R11 parOut", {31'b0, parOut}, {31'b0, mPar});
      chk("R4 R6 beWrEn", {31'b0, beWrEn}, {31'b0, mWrEn});
      if (mWrEn) begin
        chk("R6 beWrData", beWrData, mWrData);
        chk("R6 beWrMask", {28'b0, beWrMask}, {28'b0, mWrMask});
        chk("R6 beWrAddr", beWrAddr, mWrAddr);
      end
    end
  end

  // Initiator: address phase, then up to 'beats' data phases
  task automatic busCycle(input logic [3:0] cmd, input logic [31:0] addr,
                          input int beats, input logic [3:0] be, input int iw);
    bit stopped = 0;
    @(negedge clk);
    frameN = 0; irdyN = 1; adIn = addr; cbeN = cmd;
    for (int b = 0; b < beats && !stopped; b++) begin
      int  waitLeft = iw;
      int  guard = 0;
      bit  done = 0;
      @(negedge clk);
      cbeN = be ^ 4'(b);
      adIn = 32'hC0DE_0000 + 32'h0001_1111 * 32'(b);
      if (b == beats - 1) frameN = 1;
      while (!done) begin
        irdyN = (waitLeft > 0);
        if (waitLeft > 0) waitLeft--;
        #1;
        if (!trdyN && !irdyN) begin
          done = 1;
          if (!stopN) stopped = 1;
        end else if (devselN && guard >= 4) begin
          done = 1; stopped = 1;
        end
        guard++;
        if (!done) @(negedge clk);
      end
    end
    @(negedge clk);
    frameN = 1; irdyN = 1; cbeN = 4'hF; adIn = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 devselN", {31'b0, devselN}, 32'd1);
    chk("R1 trdyN", {31'b0, trdyN}, 32'd1);
    chk("R1 stopN", {31'b0, stopN}, 32'd1);
    chk("R1 adOe", {31'b0, adOe}, 32'd0);
    chk("R1 parOe", {31'b0, parOe}, 32'd0);
    chk("R1 beReq", {31'b0, beReq}, 32'd0);
    chk("R1 beWrEn", {31'b0, beWrEn}, 32'd0);
    rstN = 1; started = 1;
    @(negedge clk);

    // I/O write, byte address with low bits set (R7, R6, R9)
    rdyDelay = 0; busCycle(4'b0011, 32'h0000_1003, 1, 4'b1110, 0);
    // I/O read with backend wait states (R3, R5, R11)
    rdyDelay = 3; busCycle(4'b0010, 32'h0000_1006, 1, 4'b0000, 0);
    // I/O read asking for three beats: disconnect after one (R9)
    rdyDelay = 1; busCycle(4'b0010, 32'h0000_100D, 3, 4'b0000, 0);
    // Memory write burst with initiator waits, low bits dropped (R4, R7, R8)
    rdyDelay = 0; busCycle(4'b0111, 32'h8000_0013, 4, 4'b0101, 2);
    // Memory read burst with backend waits (R5, R8, R10)
    rdyDelay = 2; busCycle(4'b0110, 32'h8000_0FF0, 3, 4'b0000, 0);
    // Memory read burst, initiator waits on every beat (R4)
    rdyDelay = 0; busCycle(4'b0110, 32'h8000_0100, 2, 4'b0000, 1);
    // Configuration write and read (R7, R9)
    cfgSel = 1;
    rdyDelay = 1; busCycle(4'b1011, 32'h0000_012C, 2, 4'b0011, 0);
    rdyDelay = 0; busCycle(4'b1010, 32'h0000_0040, 1, 4'b0000, 0);
    // Configuration with bad low bits: not claimed (R7)
    busCycle(4'b1010, 32'h0000_0041, 1, 4'b0000, 0);
    cfgSel = 0;
    // Configuration without chip-select: not claimed (R7)
    busCycle(4'b1011, 32'h0000_0010, 1, 4'b0000, 0);
    // Reserved codes in the memory window: not claimed (R2)
    busCycle(4'b0100, 32'h8000_0000, 1, 4'b0000, 0);
    busCycle(4'b0101, 32'h8000_0004, 1, 4'b0000, 0);
    busCycle(4'b1000, 32'h8000_0008, 1, 4'b0000, 0);
    busCycle(4'b1001, 32'h8000_000C, 1, 4'b0000, 0);
    // Addresses just outside the windows (R2, R7)
    busCycle(4'b0011, 32'h0000_1010, 1, 4'b0000, 0);
    busCycle(4'b0110, 32'h8000_1000, 1, 4'b0000, 0);
    // Claimed again after the misses (R2)
    rdyDelay = 0; busCycle(4'b0111, 32'h8000_0FFC, 2, 4'b0000, 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule